// File: doc/BRIEF.md
# Sixteen-Line GPIO Controller with Per-Line Interrupt Detection

This block controls sixteen general-purpose I/O lines from a plain 16-bit register bus. Each line is turned into an output or an input by a direction register. The driven level comes from an output data register that software never writes whole. Instead it writes bit masks to a set address and a clear address, so that two agents sharing the port cannot undo each other's changes. The input levels pass through a two-flop synchronizer and can be read as one word.

Every line has its own interrupt detector. It senses either a level (high or low, chosen per line) or edges, with separate enables for rising and falling transitions, so one line can react to either edge. A line contributes to the status word only when its mask bit is clear and its enable bit is set. The OR of the gated status drives a single registered interrupt output. Edge events are sticky until a clear word is written, while a level condition stays reported for as long as it holds.

The bus is a simple strobe interface. A write takes effect on the clock edge where `bus_wr` is high. Read data is combinational from `bus_addr` while `bus_rd` is high and is zero otherwise.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset all lines are inputs (`pad_oe` = 0), output data is 0, the mask word is 0xFFFF, the enable word is 0x0000, the status word is 0 and `irq` is 0.
- R2: A direction bit of 1 drives that line (`pad_oe` bit = 1) and 0 makes it an input. The direction word is written and read at offset 0x00, and `pad_oe` follows a write on the next clock.
- R3: Writing a word to 0x18 sets every output bit whose written bit is 1, and writing to 0x1C clears such bits. Other bits are unchanged. The output word appears on `pad_out` and reads back at 0x20.
- R4: Offset 0x14 returns the levels of `pad_in` after a two-flop synchronizer. A change on `pad_in` is visible on the second clock edge after it.
- R5: A line's status bit can be 1 only while its mask bit (0x28) is 0 and its enable bit (0x2C) is 1. Edge events that arrive while the line is gated off are dropped.
- R6: A sense-select bit (0x04) of 1 puts a line in level mode. Polarity bit (0x08) 1 senses high and 0 senses low. The status bit follows the level condition, and a clear write does not remove it while the condition holds.
- R7: With sense-select 0 (edge mode), bit 1 of the rising enable word (0x0C) catches 0-to-1 transitions and bit 1 of the falling enable word (0x10) catches 1-to-0 transitions. With both bits set, the line catches either edge.
- R8: An edge status bit stays set until a word with that bit set is written to 0x34. Clear bits for other lines leave it alone.
- R9: If an enabled edge is detected on the same clock as a clear write for that line, the status bit stays set.
- R10: The status word reads at 0x30. `irq` is a register holding the OR of the status word, so it follows the status word by one clock.
- R11: Reads of unmapped offsets and of the write-only offsets 0x18, 0x1C and 0x34 return 0, and `bus_rdata` is 0 whenever `bus_rd` is low.
- R12: The sense-select, polarity, rising, falling, mask and enable words read back at their offsets exactly as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, 0 when `bus_rd` is low |
| pad_in | input | 16 | Line levels from the pads |
| pad_out | output | 16 | Levels driven on output lines |
| pad_oe | output | 16 | Per-line output enable (1 = drive) |
| irq | output | 1 | Combined interrupt request |

## Verification
Register writes show their effect at the first falling edge after the write clock, and reads are combinational, so the bench samples them half a cycle after setting the address. A pad change is seen at 0x14 two clocks later and in the status word three clocks later. `irq` comes one further clock after that. The bench counts these edges from its falling-edge drive point, and it checks on purpose one clock before each result is due as well as at the clock where it is due. For the same-clock case, the clear write is timed to land on the exact edge where the synchronized transition is first compared against its previous value.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // Register byte offsets
  localparam int unsigned OFS_DIR   = 'h00;
  localparam int unsigned OFS_SENSE = 'h04;
  localparam int unsigned OFS_POL   = 'h08;
  localparam int unsigned OFS_RISE  = 'h0C;
  localparam int unsigned OFS_FALL  = 'h10;
  localparam int unsigned OFS_DIN   = 'h14;
  localparam int unsigned OFS_OSET  = 'h18;
  localparam int unsigned OFS_OCLR  = 'h1C;
  localparam int unsigned OFS_DOUT  = 'h20;
  localparam int unsigned OFS_MASK  = 'h28;
  localparam int unsigned OFS_EN    = 'h2C;
  localparam int unsigned OFS_STAT  = 'h30;
  localparam int unsigned OFS_ICLR  = 'h34;

  // Read multiplexer select
  typedef enum logic [3:0] {
    RSEL_NONE,
    RSEL_DIR,
    RSEL_SENSE,
    RSEL_POL,
    RSEL_RISE,
    RSEL_FALL,
    RSEL_DIN,
    RSEL_DOUT,
    RSEL_MASK,
    RSEL_EN,
    RSEL_STAT
  } rsel_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] stage_d [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      assign stage_d[s] = d;
    end else begin : g_next
      assign stage_d[s] = stage_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= '0;
      end else begin
        stage_q[s] <= stage_d[s];
      end
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N  = 16,
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic          rd,
  input  logic [N-1:0]  wdata,
  output logic [N-1:0]  rdata,
  input  logic [N-1:0]  din,
  input  logic [N-1:0]  status,
  output logic [N-1:0]  dir,
  output logic [N-1:0]  sense,
  output logic [N-1:0]  pol,
  output logic [N-1:0]  rise,
  output logic [N-1:0]  fall,
  output logic [N-1:0]  mask,
  output logic [N-1:0]  en,
  output logic [N-1:0]  dout,
  output logic [N-1:0]  iclr
);

  logic [N-1:0] dir_q, sense_q, pol_q, rise_q, fall_q, mask_q, en_q, dout_q;
  logic [N-1:0] dir_d, sense_d, pol_d, rise_d, fall_d, mask_d, en_d, dout_d;
  rsel_e        rsel;

  // Next-state logic
  always_comb begin
    dir_d   = dir_q;
    sense_d = sense_q;
    pol_d   = pol_q;
    rise_d  = rise_q;
    fall_d  = fall_q;
    mask_d  = mask_q;
    en_d    = en_q;
    dout_d  = dout_q;
    iclr    = '0;
    if (wr) begin
      case (addr)
        AW'(OFS_DIR):   dir_d   = wdata;
        AW'(OFS_SENSE): sense_d = wdata;
        AW'(OFS_POL):   pol_d   = wdata;
        AW'(OFS_RISE):  rise_d  = wdata;
        AW'(OFS_FALL):  fall_d  = wdata;
        AW'(OFS_MASK):  mask_d  = wdata;
        AW'(OFS_EN):    en_d    = wdata;
        AW'(OFS_OSET):  dout_d  = dout_q | wdata;
        AW'(OFS_OCLR):  dout_d  = dout_q & ~wdata;
        AW'(OFS_ICLR):  iclr    = wdata;
        default:        ;
      endcase
    end
  end

  // Registers, clock-enabled by the write strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      sense_q <= '0;
      pol_q   <= '0;
      rise_q  <= '0;
      fall_q  <= '0;
      mask_q  <= '1;
      en_q    <= '0;
      dout_q  <= '0;
    end else if (wr) begin
      dir_q   <= dir_d;
      sense_q <= sense_d;
      pol_q   <= pol_d;
      rise_q  <= rise_d;
      fall_q  <= fall_d;
      mask_q  <= mask_d;
      en_q    <= en_d;
      dout_q  <= dout_d;
    end
  end

  // Read decode
  always_comb begin
    case (addr)
      AW'(OFS_DIR):   rsel = RSEL_DIR;
      AW'(OFS_SENSE): rsel = RSEL_SENSE;
      AW'(OFS_POL):   rsel = RSEL_POL;
      AW'(OFS_RISE):  rsel = RSEL_RISE;
      AW'(OFS_FALL):  rsel = RSEL_FALL;
      AW'(OFS_DIN):   rsel = RSEL_DIN;
      AW'(OFS_DOUT):  rsel = RSEL_DOUT;
      AW'(OFS_MASK):  rsel = RSEL_MASK;
      AW'(OFS_EN):    rsel = RSEL_EN;
      AW'(OFS_STAT):  rsel = RSEL_STAT;
      default:        rsel = RSEL_NONE;
    endcase
  end

  always_comb begin
    rdata = '0;
    if (rd) begin
      case (rsel)
        RSEL_DIR:   rdata = dir_q;
        RSEL_SENSE: rdata = sense_q;
        RSEL_POL:   rdata = pol_q;
        RSEL_RISE:  rdata = rise_q;
        RSEL_FALL:  rdata = fall_q;
        RSEL_DIN:   rdata = din;
        RSEL_DOUT:  rdata = dout_q;
        RSEL_MASK:  rdata = mask_q;
        RSEL_EN:    rdata = en_q;
        RSEL_STAT:  rdata = status;
        default:    rdata = '0;
      endcase
    end
  end

  assign dir   = dir_q;
  assign sense = sense_q;
  assign pol   = pol_q;
  assign rise  = rise_q;
  assign fall  = fall_q;
  assign mask  = mask_q;
  assign en    = en_q;
  assign dout  = dout_q;

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  input  logic [N-1:0] sense,
  input  logic [N-1:0] pol,
  input  logic [N-1:0] rise,
  input  logic [N-1:0] fall,
  input  logic [N-1:0] mask,
  input  logic [N-1:0] en,
  input  logic [N-1:0] iclr,
  output logic [N-1:0] status,
  output logic         irq
);

  logic [N-1:0] prev_q;
  logic [N-1:0] pend_q, pend_d;
  logic [N-1:0] gate;
  logic         irq_q, irq_d;

  assign gate = ~mask & en;

  for (genvar i = 0; i < N; i++) begin : g_line
    logic lvl_hit;
    logic edge_hit;
    assign lvl_hit  = (din[i] == pol[i]);
    assign edge_hit = (rise[i] & din[i] & ~prev_q[i]) |
                      (fall[i] & ~din[i] & prev_q[i]);
    assign pend_d[i] = sense[i] ? lvl_hit
                                : ((gate[i] & edge_hit) | (pend_q[i] & ~iclr[i]));
  end

  assign status = pend_q & gate;
  assign irq_d  = |status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      prev_q <= din;
      pend_q <= pend_d;
      irq_q  <= irq_d;
    end
  end

  assign irq = irq_q;

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
  parameter int unsigned NLINES = 16,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [NLINES-1:0] bus_wdata,
  output logic [NLINES-1:0] bus_rdata,
  input  logic [NLINES-1:0] pad_in,
  output logic [NLINES-1:0] pad_out,
  output logic [NLINES-1:0] pad_oe,
  output logic              irq
);

  localparam int unsigned SYNC_STAGES = 2;

  logic [1:0]        rst_pipe_q;
  logic              rst_int_n;
  logic [NLINES-1:0] din_sync;
  logic [NLINES-1:0] cfg_dir, cfg_sense, cfg_pol, cfg_rise, cfg_fall;
  logic [NLINES-1:0] cfg_mask, cfg_en, out_word, clr_word, irq_status;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe_q[1];

  gpio_sync #(.W(NLINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     (pad_in),
    .q     (din_sync)
  );

  gpio_regfile #(.N(NLINES), .AW(ADDR_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .addr   (bus_addr),
    .wr     (bus_wr),
    .rd     (bus_rd),
    .wdata  (bus_wdata),
    .rdata  (bus_rdata),
    .din    (din_sync),
    .status (irq_status),
    .dir    (cfg_dir),
    .sense  (cfg_sense),
    .pol    (cfg_pol),
    .rise   (cfg_rise),
    .fall   (cfg_fall),
    .mask   (cfg_mask),
    .en     (cfg_en),
    .dout   (out_word),
    .iclr   (clr_word)
  );

  gpio_irq_detect #(.N(NLINES)) u_det (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .din    (din_sync),
    .sense  (cfg_sense),
    .pol    (cfg_pol),
    .rise   (cfg_rise),
    .fall   (cfg_fall),
    .mask   (cfg_mask),
    .en     (cfg_en),
    .iclr   (clr_word),
    .status (irq_status),
    .irq    (irq)
  );

  assign pad_out = out_word;
  assign pad_oe  = cfg_dir;

endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N  = 16,
  parameter int unsigned AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [N-1:0]  bus_wdata,
  input logic [N-1:0]  bus_rdata,
  input logic [N-1:0]  pad_out,
  input logic [N-1:0]  pad_oe,
  input logic          irq,
  input logic [N-1:0]  status
);

  assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(OFS_DIR)) |=> pad_oe == $past(bus_wdata));

  assert_out_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(OFS_OSET)) |=> pad_out == ($past(pad_out) | $past(bus_wdata)));

  assert_out_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(OFS_OCLR)) |=> pad_out == ($past(pad_out) & ~$past(bus_wdata)));

  assert_out_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && (bus_addr == AW'(OFS_OSET) || bus_addr == AW'(OFS_OCLR))) |=> $stable(pad_out));

  assert_irq_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq == $past(|status));

  assert_idle_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> bus_rdata == '0);

endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.N(NLINES), .AW(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe),
  .irq       (irq),
  .status    (irq_status)
);

// File: tb/gpio_irq_ctrl_test.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_test;

  localparam logic [7:0] A_DIR = 8'h00, A_SENSE = 8'h04, A_POL = 8'h08, A_RISE = 8'h0C,
                         A_FALL = 8'h10, A_DIN = 8'h14, A_OSET = 8'h18, A_OCLR = 8'h1C,
                         A_DOUT = 8'h20, A_MASK = 8'h28, A_EN = 8'h2C, A_STAT = 8'h30,
                         A_ICLR = 8'h34;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [15:0] bus_wdata, bus_rdata, pad_in, pad_out, pad_oe;
  logic        irq;
  int          n_chk = 0;
  int          n_err = 0;
  logic [15:0] exp_out;

  always #10 clk = ~clk;

  gpio_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .irq(irq)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [15:0] exp);
    logic [15:0] d;
    bus_addr = a; bus_rd = 1'b1;
    #2;
    d = bus_rdata;
    bus_rd = 1'b0;
    chk(tag, d, exp);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  task automatic edge_cfg(input logic [15:0] b, input logic [15:0] re, input logic [15:0] fe);
    wr(A_SENSE, 16'h0000);
    wr(A_RISE, re);
    wr(A_FALL, fe);
    wr(A_MASK, ~b);
    wr(A_EN, b);
    wr(A_ICLR, 16'hFFFF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0; pad_in = '0;
    exp_out = '0;
    settle(3);
    rst_n = 1'b1;
    settle(4);

    // R1 reset state
    chk("R1 pad_oe", pad_oe, 16'h0000);
    chk("R1 pad_out", pad_out, 16'h0000);
    chk("R1 irq", {15'd0, irq}, 16'h0000);
    rd_chk("R1 dir", A_DIR, 16'h0000);
    rd_chk("R1 dout", A_DOUT, 16'h0000);
    rd_chk("R1 mask", A_MASK, 16'hFFFF);
    rd_chk("R1 en", A_EN, 16'h0000);
    rd_chk("R1 status", A_STAT, 16'h0000);

    // R2 direction sweep
    for (int i = 0; i < 16; i++) begin
      logic [15:0] p;
      p = (16'h1 << i) ^ 16'h5A3C;
      wr(A_DIR, p);
      chk("R2 pad_oe", pad_oe, p);
      rd_chk("R2 dir readback", A_DIR, p);
    end

    // R3 set then clear, one line at a time
    for (int i = 0; i < 16; i++) begin
      wr(A_OSET, 16'h1 << i);
      exp_out = exp_out | (16'h1 << i);
      chk("R3 set pad_out", pad_out, exp_out);
      rd_chk("R3 set readback", A_DOUT, exp_out);
    end
    foreach (exp_out[k]) begin end
    for (int i = 0; i < 16; i += 2) begin
      wr(A_OCLR, 16'h3 << i & 16'h5555 | 16'h0000);
      exp_out = exp_out & ~(16'h3 << i & 16'h5555);
      chk("R3 clear pad_out", pad_out, exp_out);
    end
    rd_chk("R3 clear readback", A_DOUT, 16'hAAAA);
    wr(A_OSET, 16'h0000);
    chk("R3 zero set no change", pad_out, 16'hAAAA);
    wr(A_OCLR, 16'hF00F);
    chk("R3 mixed clear", pad_out, 16'h0AA0);

    // R12 config readback
    wr(A_SENSE, 16'h1357); rd_chk("R12 sense", A_SENSE, 16'h1357);
    wr(A_POL, 16'h2468);   rd_chk("R12 pol", A_POL, 16'h2468);
    wr(A_RISE, 16'h9BDF);  rd_chk("R12 rise", A_RISE, 16'h9BDF);
    wr(A_FALL, 16'hACE0);  rd_chk("R12 fall", A_FALL, 16'hACE0);
    wr(A_MASK, 16'h0F0F);  rd_chk("R12 mask", A_MASK, 16'h0F0F);
    wr(A_EN, 16'h00FF);    rd_chk("R12 en", A_EN, 16'h00FF);
    wr(A_MASK, 16'hFFFF);
    wr(A_EN, 16'h0000);
    wr(A_SENSE, 16'h0000);

    // R4 synchronized input, two-clock latency
    begin
      logic [15:0] pats [5];
      logic [15:0] last;
      pats = '{16'h1234, 16'hFFFF, 16'h0000, 16'hA5C3, 16'h8001};
      last = 16'h0000;
      for (int i = 0; i < 5; i++) begin
        pad_in = pats[i];
        settle(1);
        rd_chk("R4 one clock old", A_DIN, last);
        settle(1);
        rd_chk("R4 two clocks new", A_DIN, pats[i]);
        last = pats[i];
      end
      pad_in = 16'h0000;
      settle(3);
    end

    // R11 unmapped and write-only reads
    rd_chk("R11 0x24", 8'h24, 16'h0000);
    rd_chk("R11 0x18", A_OSET, 16'h0000);
    rd_chk("R11 0x1C", A_OCLR, 16'h0000);
    rd_chk("R11 0x34", A_ICLR, 16'h0000);
    rd_chk("R11 0xFC", 8'hFC, 16'h0000);
    bus_addr = A_DIR; bus_rd = 1'b0; #2;
    chk("R11 rd low", bus_rdata, 16'h0000);

    // R7 R8 R10 rising edge sweep over all lines
    for (int i = 0; i < 16; i++) begin
      logic [15:0] b;
      b = 16'h1 << i;
      edge_cfg(b, b, 16'h0000);
      pad_in = b;
      settle(2);
      rd_chk("R7 rise not yet", A_STAT, 16'h0000);
      settle(1);
      rd_chk("R7 rise caught", A_STAT, b);
      chk("R10 irq lags status", {15'd0, irq}, 16'h0000);
      settle(1);
      chk("R10 irq high", {15'd0, irq}, 16'h0001);
      pad_in = 16'h0000;
      settle(3);
      rd_chk("R8 sticky after fall", A_STAT, b);
      wr(A_ICLR, ~b);
      rd_chk("R8 other clears ignored", A_STAT, b);
      wr(A_ICLR, b);
      rd_chk("R8 cleared", A_STAT, 16'h0000);
      settle(1);
      chk("R10 irq low", {15'd0, irq}, 16'h0000);
    end

    // R7 falling edge sweep
    for (int i = 0; i < 16; i++) begin
      logic [15:0] b;
      b = 16'h1 << i;
      edge_cfg(b, 16'h0000, b);
      pad_in = b;
      settle(3);
      rd_chk("R7 rise ignored by fall enable", A_STAT, 16'h0000);
      pad_in = 16'h0000;
      settle(3);
      rd_chk("R7 fall caught", A_STAT, b);
      wr(A_ICLR, b);
    end

    // R7 both edges on line 5
    edge_cfg(16'h0020, 16'h0020, 16'h0020);
    pad_in = 16'h0020; settle(3);
    rd_chk("R7 both rise", A_STAT, 16'h0020);
    wr(A_ICLR, 16'h0020);
    pad_in = 16'h0000; settle(3);
    rd_chk("R7 both fall", A_STAT, 16'h0020);
    wr(A_ICLR, 16'h0020);

    // R7 two lines at once
    edge_cfg(16'h8001, 16'h8001, 16'h0000);
    pad_in = 16'h8001; settle(3);
    rd_chk("R7 two lines", A_STAT, 16'h8001);
    wr(A_ICLR, 16'h0001);
    rd_chk("R8 partial clear", A_STAT, 16'h8000);
    pad_in = 16'h0000; settle(3);
    wr(A_ICLR, 16'hFFFF);

    // R5 gating
    edge_cfg(16'h0008, 16'h0008, 16'h0000);
    wr(A_MASK, 16'hFFFF); wr(A_EN, 16'h0000);
    pad_in = 16'h0008; settle(3);
    rd_chk("R5 mask1 en0", A_STAT, 16'h0000);
    pad_in = 16'h0000; settle(3);
    wr(A_EN, 16'h0008);
    pad_in = 16'h0008; settle(3);
    rd_chk("R5 mask1 en1", A_STAT, 16'h0000);
    pad_in = 16'h0000; settle(3);
    wr(A_MASK, 16'h0000); wr(A_EN, 16'h0000);
    pad_in = 16'h0008; settle(3);
    rd_chk("R5 mask0 en0", A_STAT, 16'h0000);
    wr(A_EN, 16'h0008);
    rd_chk("R5 dropped while gated", A_STAT, 16'h0000);
    settle(1);
    chk("R5 irq stays low", {15'd0, irq}, 16'h0000);
    pad_in = 16'h0000; settle(3);
    pad_in = 16'h0008; settle(3);
    rd_chk("R5 open gate", A_STAT, 16'h0008);
    wr(A_ICLR, 16'hFFFF);
    pad_in = 16'h0000; settle(3);

    // R9 edge on the same clock as clear
    edge_cfg(16'h0004, 16'h0004, 16'h0000);
    pad_in = 16'h0004;
    settle(2);
    wr(A_ICLR, 16'h0004);
    rd_chk("R9 edge beats clear", A_STAT, 16'h0004);
    wr(A_ICLR, 16'h0004);
    rd_chk("R9 later clear works", A_STAT, 16'h0000);
    pad_in = 16'h0000; settle(3);

    // R6 level mode on line 7
    wr(A_RISE, 16'h0000); wr(A_FALL, 16'h0000);
    wr(A_POL, 16'h0080);
    wr(A_SENSE, 16'h0080);
    wr(A_MASK, 16'hFF7F); wr(A_EN, 16'h0080);
    settle(1);
    rd_chk("R6 high sense, pad low", A_STAT, 16'h0000);
    pad_in = 16'h0080; settle(3);
    rd_chk("R6 high level", A_STAT, 16'h0080);
    wr(A_ICLR, 16'h0080);
    rd_chk("R6 clear has no effect", A_STAT, 16'h0080);
    pad_in = 16'h0000; settle(3);
    rd_chk("R6 level gone", A_STAT, 16'h0000);
    wr(A_POL, 16'h0000); settle(1);
    rd_chk("R6 low level", A_STAT, 16'h0080);
    settle(1);
    chk("R10 irq level", {15'd0, irq}, 16'h0001);
    wr(A_POL, 16'h0080); settle(1);
    rd_chk("R6 polarity back", A_STAT, 16'h0000);

    settle(2);
    summary();
  end

endmodule